// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a target on a two-wire I2C bus that lets a bus master read and write a small bank of 8-bit registers held inside it. SCL and SDA are brought into the system clock domain through a synchronizer and then oversampled. START, STOP and SCL edges are recognised from the synchronized samples. The block answers to a 7-bit device address. The upper six bits of that address are fixed at `101110`, and a strap input supplies the lowest bit, so two copies can share one bus.

A frame begins with the address byte and a read/write flag (1 = read). A pointer byte follows. Its low seven bits select a register, and its top bit turns on auto-advance of that pointer. A write carries its data bytes directly after the pointer byte. A read first sends the pointer byte in a write-addressed frame, then issues a repeated START, then sends the address with the read flag set. The block then shifts out register contents for as long as the master acknowledges.

SDA is only ever pulled low, as an open-drain output. Each new SDA level is applied a fixed number of system clocks after SCL is seen falling. The bus is the block's only data interface, so there is no stream handshake and no back-pressure at its edge. Clock stretching is not used, and the register bank is always ready.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, `sda_pull_o` is 0 (SDA released), and every register in the bank reads back as 0x00.
- R2: An address byte whose upper seven bits equal `101110` followed by `addr_strap` is acknowledged. The block holds `sda_pull_o` at 1 for the whole high phase of the ninth SCL clock. The strap decides which of the two addresses (0x5C or 0x5D) answers.
- R3: An address byte that does not match gets no acknowledge, and nothing else in that frame is acknowledged or written. Bits clocked on the bus after a STOP and without a new START are ignored.
- R4: In a write frame, the low seven bits of the pointer byte select the register. Each data byte that follows is stored there, and the pointer byte and every data byte are acknowledged.
- R5: If bit 7 of the pointer byte is 1, the pointer moves up by one after each data byte. If it is 0, every byte in the frame goes to the same register (writes overwrite, reads repeat).
- R6: A repeated START followed by the read address returns the register at the pointer, most significant bit first. A bit value of 0 is sent by pulling SDA low, and a 1 by releasing it.
- R7: During a read, a master acknowledge (SDA low on the ninth clock) makes the block send the next register. A missing acknowledge ends the transmission and releases SDA, and the pointer is not advanced for that byte. A STOP always returns the block to idle.
- R8: `sda_pull_o` never changes while SCL is high. It changes only in the SCL low phase, `DRIVE_DELAY` + 1 system clocks after the synchronized falling edge is detected.
- R9: With auto-advance, the pointer wraps from 127 to 0. Addresses at or above `REG_COUNT` read as 0x00, and writes to them are dropped.
- R10: The pointer and the auto-advance flag persist across frames. A read frame that carries no pointer byte starts where the previous frame left the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (wired-AND of all drivers) |
| addr_strap | input | 1 | Selects the lowest bit of the device address |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |

## Verification
The bench acts as the bus master. It runs single-byte and multi-byte writes and reads with auto-advance both on and off, so that a pointer that fails to advance, or advances when it should not, shows up as wrong data. Addresses are sent with the strap in both positions, and a non-matching address is followed by data bytes. This separates a missed acknowledge from data that should have been dropped, and a bare bit stream sent after STOP shows whether the block really returns to idle. Reads that end in a missing acknowledge are followed by a read frame without a pointer byte, and a write across pointer 127 is used as well. These patterns show whether the pointer persists and wraps correctly and whether an unacknowledged byte wrongly advances it. On every system clock of every SCL high phase, the value of `sda_pull_o` is compared with the value the master expects.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  // Kind of byte slot the slave is currently in.
  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ADDR,
    SL_SUB,
    SL_WR,
    SL_RD
  } slot_e;

  // Fixed upper six bits of the device address.
  localparam logic [5:0] DEV_PREFIX = 6'b101110;

endpackage

// File: rtl/i2c_rs_line_sync.sv
module i2c_rs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_q;
  logic              sda_q;
  logic              scl_now;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_i;
          sda_p[g] <= sda_i;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rs_sda_drive.sv
module i2c_rs_sda_drive #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic pull_next,
  output logic pull_o
);

  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      armed  <= 1'b0;
      held   <= 1'b0;
      pull_o <= 1'b0;
    end else if (load) begin
      cnt   <= CW'(DELAY);
      armed <= 1'b1;
      held  <= pull_next;
    end else if (armed) begin
      if (cnt == '0) begin
        pull_o <= held;
        armed  <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_rs_reg_bank.sv
module i2c_rs_reg_bank #(
  parameter int REG_COUNT = 16,
  parameter int AW        = 7,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (raddr == AW'(i)) rdata = regs[i];
    end
  end

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter int REG_COUNT   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DRIVE_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_strap,
  output logic sda_pull_o
);

  localparam int AW    = 7;
  localparam int DW    = 8;
  localparam int BIT_W = $clog2(DW + 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);
  localparam logic [BIT_W-1:0] ACK_BIT  = BIT_W'(DW);

  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;

  slot_e         kind;
  logic [BIT_W-1:0] bit_cnt;
  logic [DW-2:0] rx;
  logic [DW-1:0] tx;
  logic [AW-1:0] ptr;
  logic          inc;
  logic          rw;
  logic          ack;

  logic [DW-1:0] byte_in;
  logic [AW-1:0] ptr_step;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          addr_hit;
  logic          wr_en;
  logic          pull_next;

  i2c_rs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign byte_in  = {rx, sda_s};
  assign ptr_step = inc ? ptr + 1'b1 : ptr;
  assign rd_addr  = (kind == SL_ADDR) ? ptr : ptr_step;
  assign addr_hit = (byte_in[DW-1:1] == {DEV_PREFIX, addr_strap});
  assign wr_en    = scl_rise && (kind == SL_WR) && (bit_cnt == LAST_BIT);

  i2c_rs_reg_bank #(.REG_COUNT(REG_COUNT), .AW(AW), .DW(DW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (byte_in),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // Slot sequencing, sampled on synchronized SCL rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind    <= SL_IDLE;
      bit_cnt <= '0;
      rx      <= '0;
      tx      <= '0;
      ptr     <= '0;
      inc     <= 1'b0;
      rw      <= 1'b0;
      ack     <= 1'b0;
    end else if (start_det) begin
      kind    <= SL_ADDR;
      bit_cnt <= '0;
      ack     <= 1'b0;
    end else if (stop_det) begin
      kind    <= SL_IDLE;
      bit_cnt <= '0;
      ack     <= 1'b0;
    end else if (scl_rise && (kind != SL_IDLE)) begin
      if (bit_cnt != ACK_BIT) begin
        rx      <= byte_in[DW-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (kind == SL_RD) tx <= {tx[DW-2:0], 1'b0};
        if (bit_cnt == LAST_BIT) begin
          case (kind)
            SL_ADDR: begin
              if (addr_hit) begin
                ack <= 1'b1;
                rw  <= byte_in[0];
              end else begin
                ack  <= 1'b0;
                kind <= SL_IDLE;
              end
            end
            SL_SUB: begin
              ptr <= byte_in[AW-1:0];
              inc <= byte_in[DW-1];
              ack <= 1'b1;
            end
            SL_WR: begin
              ptr <= ptr_step;
              ack <= 1'b1;
            end
            default: ack <= 1'b0;
          endcase
        end
      end else begin
        bit_cnt <= '0;
        ack     <= 1'b0;
        case (kind)
          SL_ADDR: begin
            if (rw) begin
              kind <= SL_RD;
              tx   <= rd_data;
            end else begin
              kind <= SL_SUB;
            end
          end
          SL_SUB: kind <= SL_WR;
          SL_RD: begin
            if (sda_s) begin
              kind <= SL_IDLE;
            end else begin
              ptr <= ptr_step;
              tx  <= rd_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Level that SDA should take during the coming SCL low phase.
  always_comb begin
    pull_next = 1'b0;
    if (kind != SL_IDLE) begin
      if (bit_cnt == ACK_BIT) pull_next = ack && (kind != SL_RD);
      else if (kind == SL_RD) pull_next = ~tx[DW-1];
    end
  end

  i2c_rs_sda_drive #(.DELAY(DRIVE_DELAY)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (scl_fall),
    .pull_next (pull_next),
    .pull_o    (sda_pull_o)
  );

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk
  import i2c_rs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input slot_e      kind,
  input logic [3:0] bit_cnt
);

  // R8: the drive level only moves while SCL is low
  p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R3 / R7: pulling SDA starts only inside an active frame
  p_drive_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> (kind != SL_IDLE));

  // R2: a START opens a fresh address slot
  p_start_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (kind == SL_ADDR) && (bit_cnt == 4'd0));

  // R7: a STOP returns to idle
  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (kind == SL_IDLE));

  // R4: a register write lands as the eighth data bit completes
  p_write_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (kind == SL_WR) && (bit_cnt == 4'd8));

endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .wr_en      (wr_en),
  .kind       (kind),
  .bit_cnt    (bit_cnt)
);

// File: tb/sim_i2c_regslave.sv
module sim_i2c_regslave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int H         = 16;
  localparam int REG_COUNT = 16;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b1;
  logic sda_pull;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_regslave #(.REG_COUNT(REG_COUNT)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .addr_strap (strap),
    .sda_pull_o (sda_pull)
  );

  int          n_chk = 0;
  int          n_err = 0;
  logic        exp_pull = 1'b0;
  string       cur_req = "R1";
  logic [7:0]  mreg [128];
  int          mptr = 0;
  bit          minc = 1'b0;
  bit          done = 1'b0;
  logic [7:0]  wq [$];

  function automatic logic [6:0] dev();
    return {6'b101110, strap};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One SCL period; the pull level is compared on every clock of the high phase.
  task automatic bit_cycle(input logic b, output logic r);
    logic mism;
    logic seen;
    mism = 1'b0;
    seen = 1'b0;
    r    = 1'b1;
    tick(H/2);
    sda_m = b;
    tick(H/2);
    scl_m = 1'b1;
    for (int k = 0; k < H; k++) begin
      tick(1);
      if (sda_pull !== exp_pull) begin
        mism = 1'b1;
        seen = sda_pull;
      end
      if (k == H/2) r = sda_line;
    end
    scl_m = 1'b0;
    check(!mism, {"R8 ", cur_req}, "SDA pull during SCL high", int'(seen), int'(exp_pull));
  endtask

  task automatic bus_start();
    exp_pull = 1'b0;
    if (scl_m == 1'b0) begin
      tick(H/2);
      sda_m = 1'b1;
      tick(H/2);
      scl_m = 1'b1;
    end
    tick(H/2);
    sda_m = 1'b0;
    tick(H/2);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    exp_pull = 1'b0;
    tick(H/2);
    sda_m = 1'b0;
    tick(H/2);
    scl_m = 1'b1;
    tick(H/2);
    sda_m = 1'b1;
    tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic r;
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      exp_pull = 1'b0;
      bit_cycle(b[i], r);
    end
    exp_pull = exp_ack;
    bit_cycle(1'b1, r);
    exp_pull = 1'b0;
    check(r == !exp_ack, req, "acknowledge slot level", int'(r), int'(!exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] got;
    logic       r;
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      exp_pull = ~exp[i];
      bit_cycle(1'b1, r);
      got[i] = r;
    end
    exp_pull = 1'b0;
    bit_cycle(mack ? 1'b0 : 1'b1, r);
    check(got == exp, req, "read byte", int'(got), int'(exp));
  endtask

  task automatic wr_frame(input logic [6:0] a, input logic [7:0] sub, input string req);
    bit hit;
    hit = (a == dev());
    bus_start();
    send_byte({a, 1'b0}, hit, req);
    send_byte(sub, hit, req);
    if (hit) begin
      mptr = int'(sub[6:0]);
      minc = sub[7];
    end
    foreach (wq[i]) begin
      send_byte(wq[i], hit, req);
      if (hit) begin
        if (mptr < REG_COUNT) mreg[mptr] = wq[i];
        if (minc) mptr = (mptr + 1) % 128;
      end
    end
    bus_stop();
    wq.delete();
  endtask

  task automatic rd_frame(input logic [6:0] a, input bit use_sub, input logic [7:0] sub,
                          input int n, input string req);
    logic [7:0] e;
    bus_start();
    if (use_sub) begin
      send_byte({a, 1'b0}, 1'b1, req);
      send_byte(sub, 1'b1, req);
      mptr = int'(sub[6:0]);
      minc = sub[7];
      bus_start();
    end
    send_byte({a, 1'b1}, 1'b1, req);
    for (int i = 0; i < n; i++) begin
      e = (mptr < REG_COUNT) ? mreg[mptr] : 8'h00;
      recv_byte(e, i < n - 1, req);
      if ((i < n - 1) && minc) mptr = (mptr + 1) % 128;
    end
    bus_stop();
  endtask

  initial begin
    logic r;
    foreach (mreg[i]) mreg[i] = 8'h00;
    tick(5);
    check(sda_pull == 1'b0, "R1", "pull during reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    tick(5);
    check(sda_pull == 1'b0, "R1", "pull after reset", int'(sda_pull), 0);

    // R1: whole bank reads zero, auto-advance across all registers (R5)
    rd_frame(dev(), 1'b1, 8'h80, REG_COUNT, "R1");

    // R4: burst write with auto-advance, then R6 read back
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    wr_frame(dev(), 8'h83, "R4");
    rd_frame(dev(), 1'b1, 8'h83, 3, "R6");

    // R10: read with no pointer byte continues from pointer 5
    rd_frame(dev(), 1'b0, 8'h00, 2, "R10");

    // R5: pointer held when bit 7 of the pointer byte is 0
    wq.push_back(8'hAA); wq.push_back(8'hBB);
    wr_frame(dev(), 8'h09, "R5");
    rd_frame(dev(), 1'b1, 8'h09, 2, "R5");

    // R3: foreign address, no ack, nothing written
    wq.push_back(8'hEE);
    wr_frame(7'h5C, 8'h80, "R3");
    rd_frame(dev(), 1'b1, 8'h80, 1, "R3");

    // R3: bits clocked after STOP without START are ignored
    cur_req = "R3";
    exp_pull = 1'b0;
    for (int i = 0; i < 27; i++) begin
      bit_cycle((i % 3) != 1, r);
    end
    tick(H);
    scl_m = 1'b1;
    tick(H);
    rd_frame(dev(), 1'b1, 8'h80, 1, "R3");

    // R2: strap selects the low address bit
    strap = 1'b0;
    tick(4);
    wq.push_back(8'hC3);
    wr_frame(7'h5C, 8'h80, "R2");
    wq.push_back(8'h99);
    wr_frame(7'h5D, 8'h80, "R2");
    rd_frame(7'h5C, 1'b1, 8'h80, 1, "R2");
    strap = 1'b1;
    tick(4);

    // R7: a NACKed byte ends the read and does not advance the pointer
    rd_frame(dev(), 1'b1, 8'h83, 1, "R7");
    rd_frame(dev(), 1'b0, 8'h00, 2, "R7");

    // R9: pointer wraps past 127; high addresses read zero and drop writes
    wq.push_back(8'h7E); wq.push_back(8'h5A);
    wr_frame(dev(), 8'hFF, "R9");
    rd_frame(dev(), 1'b1, 8'hFE, 3, "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule